// File: doc/BRIEF.md
# Match-Capture Timer Counter

This block is a 16-bit up-counter fed through a 16-bit programmable prescaler. In timer mode the prescaler advances on every clock; in counter mode it advances only on chosen edges of one of the capture pins. The counter therefore steps once per prescaler wrap. Each of four compare registers watches the counter. When the counter wraps its prescaler while equal to a compare value, that match can set an interrupt flag, send the counter back to zero or halt it. The same match also drives a dedicated output pin through a two-bit action.

Three capture channels sample their pins through a two-stage synchronizer. On an enabled rising or falling edge, each copies the counter value into its own register and can set an interrupt flag. Software reaches everything through a flat register port: writes are synchronous and reads are combinational. The interrupt flags are cleared by writing ones to them.

Register map (word addresses): 0 control (bit 0 run, bit 1 counter mode, bits 3:2 source pin, bits 5:4 source edges), 1 prescale limit, 2 counter, 3 prescale count (read only), 4 match control, 5 output actions, 6 capture control, 7 flags, 8 match outputs, 9 to 12 compare registers 0 to 3, 13 to 15 capture registers 0 to 2. Unmapped addresses read zero.

Top module: `tmr_match_capture`

## Requirements
- R1: After reset every register reads zero, every match output is low and irq is low.
- R2: In timer mode with run set, the prescale count steps 0,1,..,limit and wraps to 0. The counter increments only on the wrap cycle, so a limit of 0 gives one count per clock.
- R3: With control bit 1 set, the prescaler steps only on edges of the capture pin chosen by control bits 3:2. Control bits 5:4 select the edges: bit 4 rising, bit 5 falling. A pin change is acted on at the second clock edge after it. A source value of 3 selects no pin.
- R4: Capture channel i copies the counter value into its register on a rising edge when capture-control bit 3i is set, and on a falling edge when bit 3i+1 is set. If bit 3i+2 is set, the same event also sets flag bit 4+i.
- R5: Match n fires on a prescaler wrap while the counter equals compare register n. If match-control bit 3n is set, it sets flag bit n.
- R6: When match-control bit 3n+1 is set, a firing match n loads zero into the counter at that wrap instead of incrementing it.
- R7: When match-control bit 3n+2 is set, a firing match n leaves the counter unchanged and clears the run bit. A simultaneous reset-on-match still zeroes the counter.
- R8: Output-action field n (bits 2n+1:2n) applies on each firing of match n: 0 keeps the output, 1 drives it low, 2 drives it high, 3 inverts it. A write to address 8 loads the outputs directly, but a match in the same cycle wins for its bit.
- R9: Writing a one to a flag bit clears it, and a flag set in the same cycle wins over the clear. irq is high exactly when any flag is set.
- R10: A write to the counter address loads the counter and clears the prescale count, taking priority over counting.
- R11: While run is clear, neither the counter nor the prescale count changes except through a counter write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr (combinational) |
| cap_in | input | 3 | Capture / count pins |
| match_out | output | 4 | Match-driven output pins |
| irq | output | 1 | OR of all interrupt flags |

## Verification
The assertions assume that each capture pin holds a level for at least one full clock. Only then does the synchronizer see every transition as one edge. They also assume writes are presented for a single clock with stable address and data. The stimulus changes pins and register inputs once per cycle, shortly after the active edge, so every level lasts a whole clock. In counter mode the stimulus only toggles the selected pin at intervals of one to three clocks. Writes to control and counter registers are kept apart from stop-on-match wraps, except where the bench's reference model defines the priority.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        ACT_HOLD   = 2'd0,
        ACT_LOW    = 2'd1,
        ACT_HIGH   = 2'd2,
        ACT_TOGGLE = 2'd3
    } match_act_e;

    localparam int A_CTRL  = 0;
    localparam int A_PRESC = 1;
    localparam int A_TC    = 2;
    localparam int A_PC    = 3;
    localparam int A_MCTL  = 4;
    localparam int A_OCTL  = 5;
    localparam int A_CCTL  = 6;
    localparam int A_FLAGS = 7;
    localparam int A_OUT   = 8;
    localparam int A_MR0   = 9;

endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = pin;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise = st_q.s1 & ~st_q.s2;
    assign fall = ~st_q.s1 & st_q.s2;

endmodule

// File: rtl/tmr_match_bank.sv
module tmr_match_bank
    import tmr_pkg::*;
#(
    parameter int N  = 4,
    parameter int TW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic [TW-1:0]   tc,
    input  logic [N*TW-1:0] mr,
    input  logic [3*N-1:0]  mctl,
    input  logic [2*N-1:0]  octl,
    input  logic            out_wr,
    input  logic [N-1:0]    out_wdata,
    output logic [N-1:0]    hit,
    output logic [N-1:0]    flag_set,
    output logic            rst_any,
    output logic            stop_any,
    output logic [N-1:0]    pins
);

    typedef struct packed {
        logic [N-1:0] pins;
    } out_t;

    out_t st_d, st_q;
    logic [N-1:0] rst_req, stop_req;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit[g]      = tick && (tc == mr[g*TW +: TW]);
        assign flag_set[g] = hit[g] && mctl[3*g];
        assign rst_req[g]  = hit[g] && mctl[3*g+1];
        assign stop_req[g] = hit[g] && mctl[3*g+2];

        // R8
        act_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (hit[g] && octl[2*g +: 2] == 2'd2) |=> pins[g]);
        // R8
        act_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (hit[g] && octl[2*g +: 2] == 2'd1) |=> !pins[g]);
        // R8
        act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (hit[g] && octl[2*g +: 2] == 2'd0 && !out_wr) |=> $stable(pins[g]));
    end

    assign rst_any  = |rst_req;
    assign stop_any = |stop_req;

    always_comb begin
        st_d = st_q;
        if (out_wr) st_d.pins = out_wdata;
        for (int n = 0; n < N; n++) begin
            if (hit[n]) begin
                case (match_act_e'(octl[2*n +: 2]))
                    ACT_LOW:    st_d.pins[n] = 1'b0;
                    ACT_HIGH:   st_d.pins[n] = 1'b1;
                    ACT_TOGGLE: st_d.pins[n] = ~st_q.pins[n];
                    default:    st_d.pins[n] = st_d.pins[n];
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pins = st_q.pins;

endmodule

// File: rtl/tmr_capture_bank.sv
module tmr_capture_bank #(
    parameter int N  = 3,
    parameter int TW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    rise,
    input  logic [N-1:0]    fall,
    input  logic [3*N-1:0]  cctl,
    input  logic [TW-1:0]   tc,
    output logic [N-1:0]    flag_set,
    output logic [N*TW-1:0] cap_flat
);

    typedef struct packed {
        logic [N-1:0][TW-1:0] cap;
    } cap_t;

    cap_t st_d, st_q;
    logic [N-1:0] evt;

    for (genvar g = 0; g < N; g++) begin : g_ch
        assign evt[g]      = (rise[g] && cctl[3*g]) || (fall[g] && cctl[3*g+1]);
        assign flag_set[g] = evt[g] && cctl[3*g+2];

        // R4
        cap_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
            evt[g] |=> (st_q.cap[g] == $past(tc)));
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N; i++) begin
            if (evt[i]) st_d.cap[i] = tc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cap_flat = st_q.cap;

endmodule

// File: rtl/tmr_match_capture.sv
module tmr_match_capture
    import tmr_pkg::*;
#(
    parameter int TC_W    = 16,
    parameter int PS_W    = 16,
    parameter int N_MATCH = 4,
    parameter int N_CAP   = 3,
    parameter int ADDR_W  = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [TC_W-1:0]    wdata,
    output logic [TC_W-1:0]    rdata,
    input  logic [N_CAP-1:0]   cap_in,
    output logic [N_MATCH-1:0] match_out,
    output logic               irq
);

    localparam int NF    = N_MATCH + N_CAP;
    localparam int A_CAP = A_MR0 + N_MATCH;

    typedef struct packed {
        logic                         run;
        logic                         mode;
        logic [1:0]                   src;
        logic [1:0]                   edge_sel;
        logic [PS_W-1:0]              presc;
        logic [PS_W-1:0]              pc;
        logic [TC_W-1:0]              tc;
        logic [3*N_MATCH-1:0]         mctl;
        logic [2*N_MATCH-1:0]         octl;
        logic [3*N_CAP-1:0]           cctl;
        logic [NF-1:0]                flags;
        logic [N_MATCH-1:0][TC_W-1:0] mr;
    } regs_t;

    regs_t st_d, st_q;

    logic [N_CAP-1:0]      rise, fall, r_sh, f_sh;
    logic [N_MATCH-1:0]    hit, m_flag;
    logic [N_CAP-1:0]      c_flag;
    logic [NF-1:0]         flag_set;
    logic                  rst_any, stop_any;
    logic                  src_evt, step, wrap, tick;
    logic                  tc_wr, ctrl_wr, flags_wr, out_wr;
    logic [N_CAP*TC_W-1:0] cap_flat;

    tmr_edge_sync #(.W(N_CAP)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin(cap_in), .rise(rise), .fall(fall)
    );

    assign r_sh    = rise >> st_q.src;
    assign f_sh    = fall >> st_q.src;
    assign src_evt = (st_q.edge_sel[0] && r_sh[0]) || (st_q.edge_sel[1] && f_sh[0]);
    assign step    = st_q.run && (!st_q.mode || src_evt);
    assign wrap    = step && (st_q.pc >= st_q.presc);
    assign tick    = wrap;

    assign tc_wr    = wr_en && (addr == ADDR_W'(A_TC));
    assign ctrl_wr  = wr_en && (addr == ADDR_W'(A_CTRL));
    assign flags_wr = wr_en && (addr == ADDR_W'(A_FLAGS));
    assign out_wr   = wr_en && (addr == ADDR_W'(A_OUT));

    tmr_match_bank #(.N(N_MATCH), .TW(TC_W)) u_match (
        .clk(clk), .rst_n(rst_n), .tick(tick), .tc(st_q.tc), .mr(st_q.mr),
        .mctl(st_q.mctl), .octl(st_q.octl), .out_wr(out_wr),
        .out_wdata(wdata[N_MATCH-1:0]), .hit(hit), .flag_set(m_flag),
        .rst_any(rst_any), .stop_any(stop_any), .pins(match_out)
    );

    tmr_capture_bank #(.N(N_CAP), .TW(TC_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall), .cctl(st_q.cctl),
        .tc(st_q.tc), .flag_set(c_flag), .cap_flat(cap_flat)
    );

    assign flag_set = {c_flag, m_flag};

    always_comb begin
        st_d = st_q;
        if (step) st_d.pc = wrap ? '0 : st_q.pc + PS_W'(1);
        if (tick) begin
            if (rst_any)        st_d.tc = '0;
            else if (!stop_any) st_d.tc = st_q.tc + TC_W'(1);
            if (stop_any)       st_d.run = 1'b0;
        end
        st_d.flags = (st_q.flags & ~(flags_wr ? wdata[NF-1:0] : '0)) | flag_set;

        if (ctrl_wr) begin
            st_d.run      = wdata[0];
            st_d.mode     = wdata[1];
            st_d.src      = wdata[3:2];
            st_d.edge_sel = wdata[5:4];
        end
        if (wr_en && addr == ADDR_W'(A_PRESC)) st_d.presc = wdata[PS_W-1:0];
        if (tc_wr) begin
            st_d.tc = wdata;
            st_d.pc = '0;
        end
        if (wr_en && addr == ADDR_W'(A_MCTL)) st_d.mctl = wdata[3*N_MATCH-1:0];
        if (wr_en && addr == ADDR_W'(A_OCTL)) st_d.octl = wdata[2*N_MATCH-1:0];
        if (wr_en && addr == ADDR_W'(A_CCTL)) st_d.cctl = wdata[3*N_CAP-1:0];
        for (int n = 0; n < N_MATCH; n++) begin
            if (wr_en && addr == ADDR_W'(A_MR0 + n)) st_d.mr[n] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(A_CTRL))  rdata = TC_W'({st_q.edge_sel, st_q.src, st_q.mode, st_q.run});
        if (addr == ADDR_W'(A_PRESC)) rdata = TC_W'(st_q.presc);
        if (addr == ADDR_W'(A_TC))    rdata = st_q.tc;
        if (addr == ADDR_W'(A_PC))    rdata = TC_W'(st_q.pc);
        if (addr == ADDR_W'(A_MCTL))  rdata = TC_W'(st_q.mctl);
        if (addr == ADDR_W'(A_OCTL))  rdata = TC_W'(st_q.octl);
        if (addr == ADDR_W'(A_CCTL))  rdata = TC_W'(st_q.cctl);
        if (addr == ADDR_W'(A_FLAGS)) rdata = TC_W'(st_q.flags);
        if (addr == ADDR_W'(A_OUT))   rdata = TC_W'(match_out);
        for (int n = 0; n < N_MATCH; n++) begin
            if (addr == ADDR_W'(A_MR0 + n)) rdata = st_q.mr[n];
        end
        for (int i = 0; i < N_CAP; i++) begin
            if (addr == ADDR_W'(A_CAP + i)) rdata = cap_flat[i*TC_W +: TC_W];
        end
    end

    assign irq = |st_q.flags;

    // R6
    match_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && rst_any && !tc_wr) |=> (st_q.tc == '0));

    // R7
    match_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && stop_any && !rst_any && !tc_wr && !ctrl_wr) |=>
        ((st_q.tc == $past(st_q.tc)) && !st_q.run));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.run && !tc_wr) |=> ($stable(st_q.tc) && $stable(st_q.pc)));

    // R9
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_wr && flag_set == '0) |=> ((st_q.flags & $past(wdata[NF-1:0])) == '0));

    // R2
    tick_only_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !tc_wr) |=> $stable(st_q.tc));

endmodule

// File: tb/tmr_match_capture_test.sv
`timescale 1ns/1ps
module tmr_match_capture_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [2:0]  cap_in = '0;
    logic [3:0]  match_out;
    logic        irq;

    int errors = 0;
    int checks = 0;

    // reference model state
    int m_run, m_mode, m_src, m_edge, m_presc, m_pc, m_tc;
    int m_mctl, m_octl, m_cctl, m_flags, m_out;
    int m_mr[4];
    int m_cap[3];
    int m_s1[3];
    int m_s2[3];

    always #4 clk = ~clk;

    tmr_match_capture uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .cap_in(cap_in), .match_out(match_out), .irq(irq)
    );

    function automatic int mread(int a);
        if (a == 0) return m_run | (m_mode << 1) | (m_src << 2) | (m_edge << 4);
        if (a == 1) return m_presc;
        if (a == 2) return m_tc;
        if (a == 3) return m_pc;
        if (a == 4) return m_mctl;
        if (a == 5) return m_octl;
        if (a == 6) return m_cctl;
        if (a == 7) return m_flags;
        if (a == 8) return m_out;
        if (a >= 9 && a <= 12) return m_mr[a-9];
        if (a >= 13 && a <= 15) return m_cap[a-13];
        return 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_mode = 0; m_src = 0; m_edge = 0; m_presc = 0; m_pc = 0; m_tc = 0;
            m_mctl = 0; m_octl = 0; m_cctl = 0; m_flags = 0; m_out = 0;
            for (int i = 0; i < 4; i++) m_mr[i] = 0;
            for (int i = 0; i < 3; i++) begin m_cap[i] = 0; m_s1[i] = 0; m_s2[i] = 0; end
        end else begin
            int rs[3];
            int fl[3];
            int ev, stp, tk, rany, sany, setf, n_pc, n_tc, n_run, n_out, n_flags, a, d;
            int n_cap[3];
            int hitv[4];
            a = int'(addr);
            d = int'(wdata);
            for (int i = 0; i < 3; i++) begin
                rs[i] = (m_s1[i] == 1 && m_s2[i] == 0) ? 1 : 0;
                fl[i] = (m_s1[i] == 0 && m_s2[i] == 1) ? 1 : 0;
            end
            ev = 0;
            if (m_src < 3)
                ev = (((m_edge & 1) != 0 && rs[m_src] == 1) || ((m_edge & 2) != 0 && fl[m_src] == 1)) ? 1 : 0;
            stp = (m_run == 1 && (m_mode == 0 || ev == 1)) ? 1 : 0;
            tk = (stp == 1 && m_pc >= m_presc) ? 1 : 0;
            n_pc = m_pc;
            if (stp == 1) n_pc = (tk == 1) ? 0 : m_pc + 1;
            rany = 0; sany = 0; setf = 0;
            for (int n = 0; n < 4; n++) begin
                hitv[n] = (tk == 1 && m_tc == m_mr[n]) ? 1 : 0;
                if (hitv[n] == 1) begin
                    if (((m_mctl >> (3*n)) & 1) != 0) setf |= (1 << n);
                    if (((m_mctl >> (3*n+1)) & 1) != 0) rany = 1;
                    if (((m_mctl >> (3*n+2)) & 1) != 0) sany = 1;
                end
            end
            n_tc = m_tc;
            n_run = m_run;
            if (tk == 1) begin
                if (rany == 1) n_tc = 0;
                else if (sany == 0) n_tc = (m_tc + 1) & 16'hFFFF;
                if (sany == 1) n_run = 0;
            end
            for (int i = 0; i < 3; i++) begin
                n_cap[i] = m_cap[i];
                if ((rs[i] == 1 && ((m_cctl >> (3*i)) & 1) != 0) ||
                    (fl[i] == 1 && ((m_cctl >> (3*i+1)) & 1) != 0)) begin
                    n_cap[i] = m_tc;
                    if (((m_cctl >> (3*i+2)) & 1) != 0) setf |= (1 << (4+i));
                end
            end
            n_out = m_out;
            if (wr_en && a == 8) n_out = d & 15;
            for (int n = 0; n < 4; n++) begin
                if (hitv[n] == 1) begin
                    case ((m_octl >> (2*n)) & 3)
                        1: n_out &= ~(1 << n);
                        2: n_out |= (1 << n);
                        3: n_out ^= (1 << n);
                        default: ;
                    endcase
                end
            end
            n_flags = m_flags;
            if (wr_en && a == 7) n_flags &= ~d;
            n_flags = (n_flags | setf) & 16'h7F;
            if (wr_en) begin
                if (a == 0) begin
                    n_run = d & 1; m_mode = (d >> 1) & 1; m_src = (d >> 2) & 3; m_edge = (d >> 4) & 3;
                end
                if (a == 1) m_presc = d;
                if (a == 2) begin n_tc = d; n_pc = 0; end
                if (a == 4) m_mctl = d & 16'hFFF;
                if (a == 5) m_octl = d & 16'hFF;
                if (a == 6) m_cctl = d & 16'h1FF;
                if (a >= 9 && a <= 12) m_mr[a-9] = d;
            end
            for (int i = 0; i < 3; i++) begin
                m_s2[i] = m_s1[i];
                m_s1[i] = int'(cap_in[i]);
                m_cap[i] = n_cap[i];
            end
            m_pc = n_pc; m_tc = n_tc; m_run = n_run; m_out = n_out; m_flags = n_flags;
        end
    end

    task automatic chk(string tag, int act, int expv, string what);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    task automatic cyc(string tag);
        @(posedge clk);
        #2;
        chk(tag, int'(match_out), m_out, "match_out");
        chk(tag, int'(irq), (m_flags != 0) ? 1 : 0, "irq");
        chk(tag, int'(rdata), mread(int'(addr)), "rdata");
    endtask

    task automatic wr(int a, int d, string tag);
        addr  = 5'(a);
        wdata = 16'(d);
        wr_en = 1'b1;
        cyc(tag);
        wr_en = 1'b0;
    endtask

    task automatic idle(int n, int a, string tag);
        addr = 5'(a);
        repeat (n) cyc(tag);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // R1: reset state of every register and output
        for (int a = 0; a < 16; a++) begin
            addr = 5'(a);
            #1;
            chk("R1", int'(rdata), 0, "reset read");
        end
        chk("R1", int'(match_out), 0, "reset match_out");
        chk("R1", int'(irq), 0, "reset irq");
        cyc("R1");

        // R2: timer mode with prescale limits 2 and 0
        wr(1, 2, "R2");
        wr(0, 1, "R2");
        idle(20, 2, "R2");
        idle(6, 3, "R2");
        wr(1, 0, "R2");
        idle(8, 2, "R2");

        // R10: counter load clears prescale count
        wr(1, 3, "R10");
        idle(2, 3, "R10");
        wr(2, 16'h00F0, "R10");
        idle(3, 3, "R10");
        idle(5, 2, "R10");

        // R11: stopped counter holds
        wr(0, 0, "R11");
        idle(6, 2, "R11");
        idle(3, 3, "R11");

        // R5 R6 R8: matches with irq, reset and output actions
        wr(2, 0, "R5");
        wr(9, 5, "R6");
        wr(10, 3, "R5");
        wr(12, 2, "R8");
        wr(4, 16'h00B, "R5");
        wr(5, 16'h4B, "R8");
        wr(8, 16'hF, "R8");
        wr(1, 1, "R6");
        wr(0, 1, "R6");
        idle(30, 7, "R5");
        idle(20, 2, "R6");
        idle(15, 8, "R8");

        // R9: write-one-to-clear while matches keep firing
        wr(7, 16'hFFFF, "R9");
        idle(4, 7, "R9");
        wr(0, 0, "R9");
        wr(7, 16'h0001, "R9");
        idle(2, 7, "R9");
        wr(7, 16'hFFFF, "R9");
        idle(2, 7, "R9");

        // R7: stop on match 2
        wr(4, 16'h140, "R7");
        wr(2, 0, "R7");
        wr(11, 8, "R7");
        wr(1, 0, "R7");
        wr(0, 1, "R7");
        idle(15, 0, "R7");
        idle(4, 2, "R7");
        wr(7, 16'hFFFF, "R7");

        // R3: counter mode on pin 1, both edges then rising only
        wr(4, 0, "R3");
        wr(2, 0, "R3");
        wr(1, 1, "R3");
        wr(0, 16'h37, "R3");
        addr = 5'(2);
        for (int k = 0; k < 24; k++) begin
            cap_in[1] = ~cap_in[1];
            repeat (1 + k % 3) cyc("R3");
        end
        wr(0, 16'h17, "R3");
        addr = 5'(3);
        for (int k = 0; k < 24; k++) begin
            if (k % 2 == 0) cap_in[1] = ~cap_in[1];
            else cap_in[0] = ~cap_in[0];
            repeat (1 + k % 2) cyc("R3");
        end
        wr(0, 16'h3F, "R3");
        idle(4, 2, "R3");
        cap_in = '0;
        idle(3, 2, "R3");

        // R4: capture channels 0 (rising, irq) and 2 (falling)
        wr(0, 0, "R4");
        wr(2, 16'h40, "R4");
        wr(1, 0, "R4");
        wr(6, 16'h085, "R4");
        wr(0, 1, "R4");
        for (int k = 0; k < 18; k++) begin
            if (k % 3 == 0) cap_in[0] = ~cap_in[0];
            if (k % 4 == 1) cap_in[2] = ~cap_in[2];
            addr = 5'((k % 3 == 0) ? 13 : (k % 3 == 1) ? 15 : 7);
            cyc("R4");
            cyc("R4");
        end

        // R5: mixed traffic with random pins and all addresses observed
        wr(7, 16'hFFFF, "R5");
        wr(6, 16'h1FF, "R5");
        wr(4, 16'h00B, "R5");
        wr(9, 7, "R5");
        wr(10, 2, "R5");
        wr(1, 0, "R5");
        wr(0, 1, "R5");
        for (int k = 0; k < 400; k++) begin
            cap_in = 3'($urandom);
            addr = 5'(k % 16);
            cyc("R5");
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule